// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns two digital supply indications and a watchdog fault strobe into a single active-low system reset. One input falls when the supply drops below the lower trip point. The other rises only when the supply has climbed past the upper trip point, so the hysteresis between the two points is already applied. Both inputs come from analog comparators outside the block. Each one passes through a two-flop synchronizer before any logic uses it. Short dips on the lower-trip input are filtered out. Only a dip of at least `GLITCH_CYC` consecutive clock cycles counts as a brown-out.

The control is a three-state machine with the states FAULT, DELAY and RUN. FAULT holds reset low and waits for the supply-good indication. DELAY holds reset low while a timer counts `RELEASE_CYC` cycles. RUN drives reset high. The transitions are:
- FAULT→DELAY when the supply is good and no qualified dip is present.
- DELAY→FAULT on a qualified dip, a loss of supply-good, or a watchdog fault.
- DELAY→RUN when the timer expires and none of those three causes is present.
- RUN→FAULT on a qualified dip or a watchdog fault.

A loss of supply-good alone does not leave RUN, because the supply is then between the two trip points. Any return to FAULT clears the timer, so the release delay always restarts from zero. A one-cycle strobe marks the first cycle of RUN, so that a companion watchdog can start again in its relaxed first-window mode. Both lengths are parameters given in clock cycles. The defaults correspond to about 6 µs of filtering and 25 ms of release delay at a 1 MHz clock.

Top module: `supv_rst_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0 and `rel_pulse` is 0.
- R2: After `rst_n` is released with the supply good, `rst_out_n` goes high on the (RELEASE_CYC+3)th rising clock edge after release. The first edge after release counts as edge 1.
- R3: A low on `vlow_n` lasting fewer than GLITCH_CYC consecutive sampled cycles leaves `rst_out_n` high.
- R4: A low on `vlow_n` lasting at least GLITCH_CYC sampled cycles, starting at edge k, drives `rst_out_n` low after edge k+GLITCH_CYC+2.
- R5: After a qualified dip of L cycles, during which `vgood` is also low, `rst_out_n` returns high after edge k+L+3+RELEASE_CYC.
- R6: Take `vgood` rising at edge k from FAULT, with one low sample at edge k+j+1. If j ≤ RELEASE_CYC−1, the delay restarts and release falls after edge k+j+4+RELEASE_CYC. Otherwise the sample is ignored and release falls after edge k+2+RELEASE_CYC.
- R7: In RUN, `vgood` low with `vlow_n` high does not assert reset.
- R8: A `wdt_fault` pulse sampled at edge k drives `rst_out_n` low after edge k. With the supply good, `rst_out_n` returns high after edge k+1+RELEASE_CYC.
- R9: `rel_pulse` is high for exactly one cycle, which is the first cycle in which `rst_out_n` is high after being low. It is never high at any other time.
- R10: Take a first `wdt_fault` at edge k from RUN. A second pulse at edge k+m+1, with 1 ≤ m ≤ RELEASE_CYC, restarts the delay, and release falls after edge k+m+2+RELEASE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| vlow_n | input | 1 | Low when the supply is below the lower trip point (asynchronous) |
| vgood | input | 1 | High when the supply is above the upper trip point (asynchronous) |
| wdt_fault | input | 1 | Synchronous one-cycle watchdog fault strobe |
| rst_out_n | output | 1 | Active-low system reset |
| rel_pulse | output | 1 | One-cycle strobe on the first cycle of reset release |

## Verification
Results fall due at different delays. A supply input passes two synchronizer flops before the filter or the state machine sees it. A watchdog strobe acts on the next edge. Release trails the DELAY entry by exactly RELEASE_CYC edges. So a qualified dip shows on the output GLITCH_CYC+2 edges after it starts, and release follows L+3+RELEASE_CYC edges after it starts. A single supply-good drop pushes release to j+4+RELEASE_CYC. The bench applies all stimulus on falling edges and samples on falling edges. It tracks the index of the edge after which each output first changes and compares that index with the closed-form value. It sweeps dip lengths across the filter threshold, drop positions across the whole delay window including the edge that would release, and second watchdog strobes across the window.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;

    // Sequencer states: reset held waiting for supply, reset held while
    // the release delay runs, and reset released.
    typedef enum logic [1:0] {
        SV_FAULT = 2'd0,
        SV_DELAY = 2'd1,
        SV_RUN   = 2'd2
    } supv_state_e;

endpackage

// File: rtl/supv_sync.sv
`timescale 1ns/1ps
module supv_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/supv_dip_filter.sv
`timescale 1ns/1ps
module supv_dip_filter #(
    parameter int GLITCH_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_low,
    output logic dip
);

    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(GLITCH_CYC);

    logic [CW-1:0] run_q;

    // Count consecutive below-trip samples; saturate at the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_q <= '0;
        else if (above_low)   run_q <= '0;
        else if (run_q != LIM) run_q <= run_q + 1'b1;
    end

    assign dip = (run_q == LIM);

endmodule

// File: rtl/supv_hold_timer.sv
`timescale 1ns/1ps
module supv_hold_timer #(
    parameter int RELEASE_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(RELEASE_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(RELEASE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Cleared whenever the sequencer is outside the delay state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!run)      cnt_q <= '0;
        else if (!done)     cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIM);

endmodule

// File: rtl/supv_rst_gen.sv
`timescale 1ns/1ps
module supv_rst_gen
    import supv_pkg::*;
#(
    parameter int GLITCH_CYC  = 6,
    parameter int RELEASE_CYC = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_n,
    input  logic vgood,
    input  logic wdt_fault,
    output logic rst_out_n,
    output logic rel_pulse
);

    logic        vlow_n_s;
    logic        vgood_s;
    logic        dip;
    logic        hold_done;
    logic        hold_run;
    logic        rel_q;
    supv_state_e state_q;
    supv_state_e state_d;

    // Lower-trip input resets to "not below" so the filter starts idle.
    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_low (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vlow_n),
        .q     (vlow_n_s)
    );

    // Supply-good resets to "not good" so release needs a real sample.
    supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_good (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vgood),
        .q     (vgood_s)
    );

    supv_dip_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_low (vlow_n_s),
        .dip       (dip)
    );

    assign hold_run = (state_q == SV_DELAY);

    supv_hold_timer #(.RELEASE_CYC(RELEASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hold_run),
        .done  (hold_done)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_FAULT: begin
                if (vgood_s && !dip && !wdt_fault) state_d = SV_DELAY;
            end
            SV_DELAY: begin
                if (dip || !vgood_s || wdt_fault) state_d = SV_FAULT;
                else if (hold_done)              state_d = SV_RUN;
            end
            SV_RUN: begin
                if (dip || wdt_fault) state_d = SV_FAULT;
            end
            default: state_d = SV_FAULT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SV_FAULT;
        else        state_q <= state_d;
    end

    // Outputs: reset level from state, release strobe on RUN entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= (state_d == SV_RUN) && (state_q != SV_RUN);
    end

    assign rst_out_n = (state_q == SV_RUN);
    assign rel_pulse = rel_q;

endmodule

// File: rtl/supv_rst_gen_chk.sv
`timescale 1ns/1ps
module supv_rst_gen_chk #(
    parameter int GLITCH_CYC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic vlow_n,
    input logic wdt_fault,
    input logic rst_out_n,
    input logic rel_pulse
);

    localparam int LW = $clog2(GLITCH_CYC + 4);
    localparam logic [LW-1:0] LSAT = LW'(GLITCH_CYC + 3);

    logic [LW-1:0] low_run_q;

    // Consecutive raw below-trip samples, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_run_q <= '0;
        else if (vlow_n)       low_run_q <= '0;
        else if (low_run_q != LSAT) low_run_q <= low_run_q + 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_holds: assert (!rst_out_n && !rel_pulse)
                else $error("R1 outputs active during block reset");
        end
    end

    a_r4_long_dip_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run_q == LSAT) |-> !rst_out_n)
        else $error("R4 long dip did not assert reset");

    a_r8_wdt_resets: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_fault |=> !rst_out_n)
        else $error("R8 watchdog fault did not assert reset");

    a_r9_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> rel_pulse)
        else $error("R9 missing release strobe");

    a_r9_strobe_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |-> (rst_out_n && !$past(rst_out_n)))
        else $error("R9 strobe outside release");

endmodule

bind supv_rst_gen supv_rst_gen_chk #(.GLITCH_CYC(GLITCH_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vlow_n    (vlow_n),
    .wdt_fault (wdt_fault),
    .rst_out_n (rst_out_n),
    .rel_pulse (rel_pulse)
);

// File: tb/supv_rst_gen_tb.sv
`timescale 1ns/1ps
module supv_rst_gen_tb;

    localparam int G = 4;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic vlow_n = 1'b1;
    logic vgood = 1'b1;
    logic wdt = 1'b0;
    logic rst_out_n;
    logic rel_pulse;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    supv_rst_gen #(.GLITCH_CYC(G), .RELEASE_CYC(R)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vlow_n    (vlow_n),
        .vgood     (vgood),
        .wdt_fault (wdt),
        .rst_out_n (rst_out_n),
        .rel_pulse (rel_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Index i means "after rising edge k+i", k being the first edge
    // after the call; stimulus set here is seen from edge k+i+1.
    task automatic watch(input int n, input int restore_at, input int drop_at,
                         input int wdt_at, output int fall_i, output int rise_i,
                         output int pulses, output int pulse_i);
        logic prev;
        prev = rst_out_n;
        fall_i = -1; rise_i = -1; pulses = 0; pulse_i = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n && prev && fall_i < 0) fall_i = i;
            if (rst_out_n && !prev && rise_i < 0) rise_i = i;
            if (rel_pulse) begin
                pulses++;
                if (pulse_i < 0) pulse_i = i;
            end
            prev = rst_out_n;
            wdt = (i == wdt_at);
            if (i == drop_at) vgood = 1'b0;
            if (i == restore_at) begin
                vgood = 1'b1;
                vlow_n = 1'b1;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f, r, p, pi, exp_r;
        #1 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 rst_out_n in reset", rst_out_n, 0);
            check("R1 rel_pulse in reset", rel_pulse, 0);
        end
        rst_n = 1'b1;
        watch(R + 10, -1, -1, -1, f, r, p, pi);
        check("R2 power-up release index", r, R + 2);
        check("R9 power-up strobe count", p, 1);
        check("R9 power-up strobe index", pi, R + 2);
        idle(5);

        // Dip length sweep across the filter threshold (R3, R4, R5, R9).
        for (int L = 1; L <= G + 3; L++) begin
            vlow_n = 1'b0;
            vgood = 1'b0;
            watch(L + R + 10, L - 1, -1, -1, f, r, p, pi);
            if (L < G) begin
                check("R3 short dip ignored", f, -1);
                check("R3 short dip no strobe", p, 0);
            end else begin
                check("R4 dip fall index", f, G + 2);
                check("R5 dip release index", r, L + 3 + R);
                check("R9 dip strobe index", pi, L + 3 + R);
                check("R9 dip strobe count", p, 1);
            end
            idle(5);
        end

        // R7: supply between trip points while running.
        vgood = 1'b0;
        watch(30, -1, -1, -1, f, r, p, pi);
        check("R7 hysteresis keeps run", f, -1);
        check("R7 still released", rst_out_n, 1);

        // R8: watchdog fault with supply not good holds reset.
        wdt = 1'b1;
        watch(15, -1, -1, -1, f, r, p, pi);
        check("R8 fault fall index", f, 0);
        check("R8 no release without supply", r, -1);

        // R6: single supply-good drop at each position of the delay.
        for (int j = 0; j <= R + 2; j++) begin
            vgood = 1'b0;
            wdt = 1'b1;
            @(negedge clk);
            wdt = 1'b0;
            idle(4);
            check("R6 setup in fault", rst_out_n, 0);
            vgood = 1'b1;
            watch(j + R + 10, j + 1, j, -1, f, r, p, pi);
            exp_r = (j <= R - 1) ? (j + 4 + R) : (2 + R);
            check("R6 release after drop", r, exp_r);
            check("R9 drop strobe count", p, 1);
        end
        idle(5);

        // R8: watchdog fault from run with supply good.
        wdt = 1'b1;
        watch(R + 10, -1, -1, -1, f, r, p, pi);
        check("R8 fault fall index", f, 0);
        check("R8 fault release index", r, 1 + R);
        idle(5);

        // R10: second fault at each position of the delay.
        for (int m = 1; m <= R; m++) begin
            wdt = 1'b1;
            watch(m + R + 8, -1, -1, m, f, r, p, pi);
            check("R10 restart release index", r, m + 2 + R);
            check("R10 restart strobe count", p, 1);
            idle(3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule